// File: doc/BRIEF.md
# Power-On Reset Timeout Sequencer

This block drives the internal reset of a small processor core. After a power-on pulse it runs a chain of waits. The first is a power-up wait timed by a slow RC tick. The next is a start-up count of main-clock cycles, used in the crystal oscillator modes. The last is a PLL lock wait. The reset output is held until every enabled wait has expired. Configuration inputs decide which waits take part, so the chain ranges from no wait at all up to all three stages.

A supply-good flag is filtered against a minimum low time before it counts as a brown-out. A brown-out holds the core in reset for as long as the flag stays low. After recovery only the power-up wait is repeated. The active-low clear pin holds reset on its own and does not delay the waits, which are timed from the power-on pulse. A wake event from sleep runs the start-up count and the PLL wait again. In that case the block stalls execution instead of resetting the core. A sticky flag records whether the most recent reset was caused by a brown-out.

The whole block runs on one clock, the main oscillator. The RC tick arrives as a one-cycle enable pulse.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1, `exec_stall_o` is 0 and `cause_bor_o` is 0.
- R2: When the power-up wait is enabled, it starts on the first clock edge after `por_i` falls and lasts exactly 72 RC ticks. Every later stage starts only after it ends.
- R3: The oscillator start-up stage lasts exactly 1024 clock cycles. It runs only when `cfg_osc_mode_i` is 1, 2 or 3 (the crystal modes). Mode 0 is the RC mode and skips it.
- R4: When `cfg_pll_en_i` is 1, a lock wait of exactly 2 RC ticks follows the start-up stage. `core_rst_o` falls on the edge that ends the last enabled stage.
- R5: In mode 0 with the power-up wait and the PLL disabled, `core_rst_o` falls on the first clock edge after `por_i` falls.
- R6: With `cfg_bor_en_i` at 1, a brown-out trips on the 4th RC tick seen while `bor_ok_i` has stayed continuously low. A low spell covering fewer ticks is ignored. With `cfg_bor_en_i` at 0, a low `bor_ok_i` is ignored.
- R7: During a brown-out `core_rst_o` stays 1 while `bor_ok_i` is low. After recovery only the 72-tick power-up wait runs (when enabled), with no start-up count and no PLL wait.
- R8: If `bor_ok_i` goes low while the power-up wait runs and brown-out is enabled, the block returns to brown-out on the next edge, with no filtering. The wait restarts from zero once the flag recovers.
- R9: `core_rst_o` is 1 on the edge after any edge that samples `mclr_n_i` low. When the waits have expired, it falls on the first edge that samples `mclr_n_i` high.
- R10: `cause_bor_o` is set by a brown-out and stays 1 until the next `por_i` pulse.
- R11: A `wake_i` pulse sampled while the core runs sets `exec_stall_o` for the start-up count in crystal modes, followed by the PLL wait when enabled, and keeps `core_rst_o` at 0. In mode 0 without the PLL, a wake is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bor_ok_i | input | 1 | Supply-good comparator flag, 0 means low supply |
| mclr_n_i | input | 1 | External clear, active low |
| wake_i | input | 1 | Wake-from-sleep event pulse |
| rc_tick_i | input | 1 | One-cycle pulse per slow RC period |
| cfg_pwrt_en_i | input | 1 | Enable the power-up wait |
| cfg_bor_en_i | input | 1 | Enable brown-out detection |
| cfg_pll_en_i | input | 1 | Enable the PLL lock wait |
| cfg_osc_mode_i | input | 2 | 0 RC, 1 LP, 2 XT, 3 HS |
| core_rst_o | output | 1 | Core reset, active high |
| exec_stall_o | output | 1 | Execution stall during a wake wait |
| cause_bor_o | output | 1 | Last reset came from a brown-out |

## Verification
A stage counter left in a wrong state, or a wrong stage order, moves the falling edge of `core_rst_o` by whole RC periods or by 1024 cycles. The bench therefore checks the cycle just before and the cycle of each release. A filter that counts wrongly shows up within one RC period of the 4th tick, either as a reset or as a missing reset. A brown-out path that loses its origin adds 1024 cycles to the recovery. A wake handled as a reset raises `core_rst_o` on the very next edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_POR  = 3'd0,
        ST_PWRT = 3'd1,
        ST_OST  = 3'd2,
        ST_PLL  = 3'd3,
        ST_RUN  = 3'd4,
        ST_BOR  = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       wake;
        logic       cause_bor;
        logic       core_rst;
        logic       stall;
    } seq_regs_t;

    function automatic logic is_crystal(input logic [1:0] mode);
        return mode != 2'd0;
    endfunction

endpackage

// File: rtl/bor_filter.sv
module bor_filter #(
    parameter int MIN_TICKS = 4
) (
    input  logic clk,
    input  logic por_i,
    input  logic en_i,
    input  logic supply_ok_i,
    input  logic tick_i,
    output logic trip_o
);
    localparam int FW = $clog2(MIN_TICKS + 1);

    logic [FW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || supply_ok_i)
            cnt_d = '0;
        else if (tick_i && cnt_q != FW'(MIN_TICKS))
            cnt_d = cnt_q + 1'b1;
        trip_o = en_i && !supply_ok_i && tick_i && (cnt_q == FW'(MIN_TICKS - 1));
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    // a trip needs the flag to have been low on the previous edge too
    assert_trip_after_low_R6: assert property (@(posedge clk) disable iff (por_i)
        trip_o |-> !$past(supply_ok_i));

endmodule

// File: rtl/stage_counter.sv
module stage_counter #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          por_i,
    input  logic          clear_i,
    input  logic          step_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)     cnt_d = '0;
        else if (step_i) cnt_d = cnt_q + 1'b1;
        expire_o = step_i && (cnt_q == limit_i - 1'b1);
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq #(
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024,
    parameter int PLL_TICKS  = 2,
    parameter int BOR_TICKS  = 4
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       bor_ok_i,
    input  logic       mclr_n_i,
    input  logic       wake_i,
    input  logic       rc_tick_i,
    input  logic       cfg_pwrt_en_i,
    input  logic       cfg_bor_en_i,
    input  logic       cfg_pll_en_i,
    input  logic [1:0] cfg_osc_mode_i,
    output logic       core_rst_o,
    output logic       exec_stall_o,
    output logic       cause_bor_o
);
    import rstseq_pkg::*;

    localparam int MAXA = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
    localparam int MAXD = (MAXA > PLL_TICKS) ? MAXA : PLL_TICKS;
    localparam int CW   = $clog2(MAXD + 1);

    seq_regs_t     r_d, r_q;
    logic          bor_trip;
    logic          stage_done;
    logic          cnt_clear;
    logic          cnt_step;
    logic [CW-1:0] cnt_limit;
    logic          xtal;

    assign xtal = is_crystal(cfg_osc_mode_i);

    bor_filter #(.MIN_TICKS(BOR_TICKS)) u_filter (
        .clk         (clk),
        .por_i       (por_i),
        .en_i        (cfg_bor_en_i),
        .supply_ok_i (bor_ok_i),
        .tick_i      (rc_tick_i),
        .trip_o      (bor_trip)
    );

    stage_counter #(.CW(CW)) u_count (
        .clk      (clk),
        .por_i    (por_i),
        .clear_i  (cnt_clear),
        .step_i   (cnt_step),
        .limit_i  (cnt_limit),
        .expire_o (stage_done)
    );

    always_comb begin
        case (r_q.state)
            ST_PWRT: begin cnt_step = rc_tick_i; cnt_limit = CW'(PWRT_TICKS); end
            ST_OST:  begin cnt_step = 1'b1;      cnt_limit = CW'(OST_CYCLES); end
            ST_PLL:  begin cnt_step = rc_tick_i; cnt_limit = CW'(PLL_TICKS);  end
            default: begin cnt_step = 1'b0;      cnt_limit = CW'(1);          end
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_POR: begin
                if (cfg_pwrt_en_i)     r_d.state = ST_PWRT;
                else if (xtal)         r_d.state = ST_OST;
                else if (cfg_pll_en_i) r_d.state = ST_PLL;
                else                   r_d.state = ST_RUN;
            end
            ST_PWRT: begin
                if (cfg_bor_en_i && !bor_ok_i) begin
                    r_d.state     = ST_BOR;
                    r_d.cause_bor = 1'b1;
                end else if (stage_done) begin
                    if (r_q.cause_bor)     r_d.state = ST_RUN;
                    else if (xtal)         r_d.state = ST_OST;
                    else if (cfg_pll_en_i) r_d.state = ST_PLL;
                    else                   r_d.state = ST_RUN;
                end
            end
            ST_OST: begin
                if (stage_done) r_d.state = cfg_pll_en_i ? ST_PLL : ST_RUN;
            end
            ST_PLL: begin
                if (stage_done) r_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (wake_i) begin
                    if (xtal)              r_d.state = ST_OST;
                    else if (cfg_pll_en_i) r_d.state = ST_PLL;
                    r_d.wake = xtal || cfg_pll_en_i;
                end
            end
            ST_BOR: begin
                if (bor_ok_i) r_d.state = cfg_pwrt_en_i ? ST_PWRT : ST_RUN;
            end
            default: r_d.state = ST_POR;
        endcase

        if (bor_trip && (r_q.state == ST_OST || r_q.state == ST_PLL || r_q.state == ST_RUN)) begin
            r_d.state     = ST_BOR;
            r_d.cause_bor = 1'b1;
        end

        if (r_d.state == ST_RUN || r_d.state == ST_BOR)
            r_d.wake = 1'b0;

        r_d.core_rst = !mclr_n_i || (r_d.state != ST_RUN && !r_d.wake);
        r_d.stall    = r_d.wake;
        cnt_clear    = (r_d.state != r_q.state);
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            r_q.state     <= ST_POR;
            r_q.wake      <= 1'b0;
            r_q.cause_bor <= 1'b0;
            r_q.core_rst  <= 1'b1;
            r_q.stall     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign core_rst_o   = r_q.core_rst;
    assign exec_stall_o = r_q.stall;
    assign cause_bor_o  = r_q.cause_bor;

    assert_ost_crystal_only_R3: assert property (@(posedge clk) disable iff (por_i)
        (r_q.state == ST_OST) |-> (cfg_osc_mode_i != 2'd0));

    assert_bor_needs_enable_R6: assert property (@(posedge clk) disable iff (por_i)
        $rose(cause_bor_o) |-> ($past(cfg_bor_en_i) && !$past(bor_ok_i)));

    assert_pwrt_drop_restart_R8: assert property (@(posedge clk) disable iff (por_i)
        (r_q.state == ST_PWRT && cfg_bor_en_i && !bor_ok_i) |=> (r_q.state == ST_BOR));

    assert_mclr_holds_R9: assert property (@(posedge clk) disable iff (por_i)
        !$past(mclr_n_i) |-> core_rst_o);

    assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (por_i)
        cause_bor_o |=> cause_bor_o);

    assert_wake_no_reset_R11: assert property (@(posedge clk) disable iff (por_i)
        (exec_stall_o && $past(mclr_n_i)) |-> !core_rst_o);

endmodule

// File: tb/rst_timeout_seq_test.sv
module rst_timeout_seq_test;

    localparam int DIV   = 8;
    localparam int PWRT  = 72;
    localparam int OST   = 1024;
    localparam int PLLT  = 2;

    logic       clk = 1'b0;
    logic       por_i = 1'b0;
    logic       bor_ok_i = 1'b1;
    logic       mclr_n_i = 1'b1;
    logic       wake_i = 1'b0;
    logic       rc_tick_i = 1'b0;
    logic       cfg_pwrt_en_i = 1'b1;
    logic       cfg_bor_en_i = 1'b1;
    logic       cfg_pll_en_i = 1'b0;
    logic [1:0] cfg_osc_mode_i = 2'd0;
    logic       core_rst_o, exec_stall_o, cause_bor_o;

    int ecount = 0;
    int cyc = 0;
    int checks = 0;
    int fails = 0;

    rst_timeout_seq uut (
        .clk            (clk),
        .por_i          (por_i),
        .bor_ok_i       (bor_ok_i),
        .mclr_n_i       (mclr_n_i),
        .wake_i         (wake_i),
        .rc_tick_i      (rc_tick_i),
        .cfg_pwrt_en_i  (cfg_pwrt_en_i),
        .cfg_bor_en_i   (cfg_bor_en_i),
        .cfg_pll_en_i   (cfg_pll_en_i),
        .cfg_osc_mode_i (cfg_osc_mode_i),
        .core_rst_o     (core_rst_o),
        .exec_stall_o   (exec_stall_o),
        .cause_bor_o    (cause_bor_o)
    );

    always #5 clk = ~clk;

    // edge numbering from the fall of por_i; RC tick on every DIV-th edge
    always @(posedge clk) begin
        if (por_i) begin
            ecount = 0;
            rc_tick_i <= 1'b0;
        end else begin
            ecount = ecount + 1;
            rc_tick_i <= ((ecount + 1) % DIV) == 0;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 200000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 200000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input logic act, input logic exp, input string req);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %b expected %b at edge %0d", req, act, exp, ecount);
        end
    endtask

    task automatic wait_edge(input int n);
        while (ecount < n) @(negedge clk);
    endtask

    function automatic int after_pll(input int p, input bit pll);
        return pll ? (p / DIV) * DIV + PLLT * DIV : p;
    endfunction

    function automatic int exp_por_release(input bit pwrt, input logic [1:0] mode, input bit pll);
        int p;
        p = pwrt ? PWRT * DIV : 1;
        if (mode != 2'd0) p = p + OST;
        return after_pll(p, pll);
    endfunction

    function automatic int exp_wake_end(input int w, input logic [1:0] mode, input bit pll);
        int p;
        p = w;
        if (mode != 2'd0) p = p + OST;
        return after_pll(p, pll);
    endfunction

    task automatic do_por(input bit pwrt, input logic [1:0] mode, input bit pll, input bit boren);
        @(negedge clk);
        cfg_pwrt_en_i = pwrt;
        cfg_osc_mode_i = mode;
        cfg_pll_en_i = pll;
        cfg_bor_en_i = boren;
        bor_ok_i = 1'b1;
        wake_i = 1'b0;
        por_i = 1'b1;
        repeat (3) @(negedge clk);
        check(core_rst_o, 1'b1, "R1 reset during por");
        check(exec_stall_o, 1'b0, "R1 stall during por");
        check(cause_bor_o, 1'b0, "R1/R10 cause cleared by por");
        por_i = 1'b0;
    endtask

    task automatic expect_release(input int e, input string req);
        if (e > 1) begin
            wait_edge(e - 1);
            check(core_rst_o, 1'b1, req);
        end
        wait_edge(e);
        check(core_rst_o, 1'b0, req);
    endtask

    initial begin
        bit bad;
        int rel;
        int w;
        void'($urandom(32'h5EED));
        #1 por_i = 1'b1;

        // R2, R3, R4: full chain XT + PLL
        do_por(1'b1, 2'd2, 1'b1, 1'b1);
        rel = exp_por_release(1'b1, 2'd2, 1'b1);
        expect_release(rel, "R4 release after pwrt+ost+pll");

        // R6: short dip covering three ticks is ignored
        wait_edge(rel + 8);
        bor_ok_i = 1'b0;
        bad = 1'b0;
        while (ecount < rel + 32) begin
            @(negedge clk);
            if (core_rst_o !== 1'b0) bad = 1'b1;
        end
        bor_ok_i = 1'b1;
        check(bad, 1'b0, "R6 short dip ignored");
        check(cause_bor_o, 1'b0, "R6 no cause after short dip");

        // R6, R10: long dip trips on fourth tick
        wait_edge(rel + 40);
        bor_ok_i = 1'b0;
        wait_edge(rel + 71);
        check(core_rst_o, 1'b0, "R6 no trip before fourth tick");
        wait_edge(rel + 72);
        check(core_rst_o, 1'b1, "R6 trip on fourth tick");
        check(cause_bor_o, 1'b1, "R10 cause set by brown-out");
        // R7: held while low, then only the power-up wait
        wait_edge(rel + 104);
        check(core_rst_o, 1'b1, "R7 held while supply low");
        bor_ok_i = 1'b1;
        expect_release(rel + 104 + PWRT * DIV, "R7 recovery uses power-up wait only");
        check(cause_bor_o, 1'b1, "R10 cause stays set");

        // R11: wake in XT with PLL stalls without reset
        w = rel + 104 + PWRT * DIV + 8;
        wait_edge(w - 1);
        wake_i = 1'b1;
        wait_edge(w);
        wake_i = 1'b0;
        check(exec_stall_o, 1'b1, "R11 stall after wake");
        check(core_rst_o, 1'b0, "R11 no reset on wake");
        rel = exp_wake_end(w, 2'd2, 1'b1);
        wait_edge(rel - 1);
        check(exec_stall_o, 1'b1, "R11 stall held through wake wait");
        wait_edge(rel);
        check(exec_stall_o, 1'b0, "R11 stall ends after ost+pll");

        // R8: drop during power-up wait restarts it; R10 cleared by por
        do_por(1'b1, 2'd0, 1'b0, 1'b1);
        wait_edge(200);
        bor_ok_i = 1'b0;
        wait_edge(201);
        bor_ok_i = 1'b1;
        check(cause_bor_o, 1'b1, "R8 immediate brown-out in power-up wait");
        expect_release(200 + PWRT * DIV, "R8 power-up wait restarted");
        do_por(1'b0, 2'd0, 1'b0, 1'b1);

        // R5: RC, no wait, releases on first edge
        expect_release(1, "R5 immediate release");
        // R11: wake ignored in RC without PLL
        wait_edge(10);
        wake_i = 1'b1;
        wait_edge(11);
        wake_i = 1'b0;
        bad = 1'b0;
        while (ecount < 20) begin
            @(negedge clk);
            if (exec_stall_o !== 1'b0 || core_rst_o !== 1'b0) bad = 1'b1;
        end
        check(bad, 1'b0, "R11 wake ignored in RC mode");
        // R6: brown-out disabled ignores a long low
        do_por(1'b0, 2'd0, 1'b0, 1'b0);
        wait_edge(8);
        bor_ok_i = 1'b0;
        bad = 1'b0;
        while (ecount < 80) begin
            @(negedge clk);
            if (core_rst_o !== 1'b0) bad = 1'b1;
        end
        bor_ok_i = 1'b1;
        check(bad, 1'b0, "R6 disabled detector ignores low supply");
        check(cause_bor_o, 1'b0, "R6 no cause when disabled");

        // R9: clear pin held through the waits
        @(negedge clk);
        mclr_n_i = 1'b0;
        do_por(1'b0, 2'd3, 1'b0, 1'b1);
        wait_edge(1100);
        check(core_rst_o, 1'b1, "R9 held by clear pin after waits");
        mclr_n_i = 1'b1;
        wait_edge(1101);
        check(core_rst_o, 1'b0, "R9 release on clear pin rise");

        // R2, R3, R4, R5: random configurations
        for (int i = 0; i < 8; i++) begin
            bit pw, pl;
            logic [1:0] md;
            pw = 1'($urandom);
            pl = 1'($urandom);
            md = 2'($urandom);
            do_por(pw, md, pl, 1'b1);
            expect_release(exp_por_release(pw, md, pl), "R2/R3 random chain release");
        end

        summary();
        $finish;
    end

endmodule